// File: doc/BRIEF.md
# Sixteen-bit ALU with conditional add

This block is the purely combinational arithmetic and logic unit of a three-operand, sixteen-bit register machine. Each instruction computes `dest = Y op X`, and this unit performs the `op` step. The caller supplies the operands that have already been fetched, the 4-bit operation code, the raw 4-bit X field of the instruction and the current flags. The unit returns the result, the next flag value and a strobe that says whether the flags are to be written.

Three features set it apart from a plain ALU. Some operations take an in-place immediate, a small signed count or addend packed into the instruction's X field. Silent operations leave the flags alone. A conditional add reads a condition code and a 13-bit signed offset packed inside X. With the program counter as Y, that conditional add is the machine's only branch primitive. Operand fetch, memory access and write-back are handled outside the unit.

Top module: `cadd_alu`

## Requirements
- R1: Op 0 (silent) and op 1 (flag-writing) add Y and an in-place immediate. The immediate is the 4-bit X field `{indirect bit, 3-bit register code}` read as two's complement (-8..+7) and sign-extended to 16 bits.
- R2: Op 2 (silent), op 3 and op 4 add Y and X. Op 4 also adds the incoming carry. C is the unsigned carry out of bit 15, and V is set on signed overflow.
- R3: Ops 0, 2 and 11 never write the flags. flags_we_o is 0 and flags_o equals flags_i. Every other op from 1 to 13 drives flags_we_o to 1.
- R4: Op 5 computes Y-X and op 6 computes Y-X-C. C is set on unsigned borrow and V on signed overflow. Op 10 sets the flags exactly as op 5 would, but its result is Y unchanged.
- R5: Op 7 is AND, op 8 is OR and op 9 is XOR. All three clear C and V.
- R6: Op 11 splits X into a condition code in X[15:13] and an offset in X[12:0], sign-extended to -4096..+4095. The result is Y+offset when the condition holds and Y when it does not.
- R7: The op 11 condition codes are 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set and 7 always. The flag bits are Z=bit0, C=bit1, N=bit2 and V=bit3.
- R8: Op 12 rotates Y right cyclically by the low 4 bits of the X field. Op 13 rotates by X[3:0]. In both cases the count is taken modulo 16. C takes the last bit rotated out, which is result bit 15, and V is cleared.
- R9: A rotate whose count modulo 16 is zero returns Y unchanged and leaves C at its incoming value.
- R10: Reserved ops 14 and 15 return Y and do not write the flags.
- R11: On every flag write, Z is (value==0) and N is value bit 15. The value is the result, except for op 10, where it is the difference Y-X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| y_i | input | 16 | Y operand |
| x_i | input | 16 | X operand |
| xfield_i | input | 4 | Raw X field: indirect bit (MSB) and register code |
| flags_i | input | 4 | Current flags {V,N,C,Z} |
| result_o | output | 16 | Operation result |
| flags_o | output | 4 | Next flags (equal to flags_i when not written) |
| flags_we_o | output | 1 | Flag write strobe |

## Verification
The conditional add is the hardest case to reach. Its outcome depends jointly on three bits of X and on one particular bit of the incoming flags, so uniform random vectors exercise each condition code with its predicate true and false only a few times. The stimulus therefore runs a directed sweep over all eight condition codes against both polarities of the flag each code tests, with positive and negative offsets including both offset extremes. The same approach reaches the rotate count of zero modulo 16, which needs specific field values (0, or a register count of 16 or 32): those counts are forced directly, for both rotate forms, with the incoming carry set both ways.

// File: rtl/cadd_alu_pkg.sv
package cadd_alu_pkg;
  localparam int DW     = 16;
  localparam int FLD_W  = 4;
  localparam int COND_W = 3;
  localparam int OFS_W  = DW - COND_W;
  localparam int SH_W   = $clog2(DW);

  typedef enum logic [3:0] {
    OP_ADDIS = 4'd0,  OP_ADDI = 4'd1,  OP_ADDS = 4'd2,  OP_ADD  = 4'd3,
    OP_ADC   = 4'd4,  OP_SUB  = 4'd5,  OP_SBC  = 4'd6,  OP_AND  = 4'd7,
    OP_OR    = 4'd8,  OP_XOR  = 4'd9,  OP_CMP  = 4'd10, OP_CADD = 4'd11,
    OP_RRCI  = 4'd12, OP_RRC  = 4'd13, OP_RSV0 = 4'd14, OP_RSV1 = 4'd15
  } alu_op_e;

  localparam int FZ = 0;
  localparam int FC = 1;
  localparam int FN = 2;
  localparam int FV = 3;

  // Adder: returns {carry_out, sum}
  function automatic logic [DW:0] add_c(input logic [DW-1:0] a,
                                        input logic [DW-1:0] b,
                                        input logic cin);
    return {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
  endfunction

  // Cyclic right rotate by n (n < DW)
  function automatic logic [DW-1:0] rotr(input logic [DW-1:0] v,
                                         input logic [SH_W-1:0] n);
    logic [2*DW-1:0] dbl;
    dbl = {v, v} >> n;
    return dbl[DW-1:0];
  endfunction

  function automatic logic cond_eval(input logic [COND_W-1:0] cc,
                                     input logic [3:0] f);
    logic base;
    case (cc[2:1])
      2'd0:    base = f[FZ];
      2'd1:    base = f[FC];
      2'd2:    base = f[FN];
      default: base = f[FV];
    endcase
    return (cc == 3'd7) ? 1'b1 : (base ^ cc[0]);
  endfunction
endpackage

// File: rtl/cadd_alu_opdec.sv
module cadd_alu_opdec
  import cadd_alu_pkg::*;
(
  input  logic [FLD_W-1:0] xfield_i,
  input  logic [DW-1:0]    x_i,
  input  logic [3:0]       flags_i,
  output logic [DW-1:0]    imm_o,
  output logic [DW-1:0]    ofs_o,
  output logic             cond_true_o
);
  localparam int IMM_PAD = DW - FLD_W;
  localparam int OFS_PAD = DW - OFS_W;

  assign imm_o       = {{IMM_PAD{xfield_i[FLD_W-1]}}, xfield_i};
  assign ofs_o       = {{OFS_PAD{x_i[OFS_W-1]}}, x_i[OFS_W-1:0]};
  assign cond_true_o = cond_eval(x_i[DW-1:OFS_W], flags_i);
endmodule

// File: rtl/cadd_alu_arith.sv
module cadd_alu_arith
  import cadd_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          use_c_i,
  input  logic          c_i,
  output logic [DW-1:0] sum_o,
  output logic          c_o,
  output logic          v_o
);
  logic [DW-1:0] b_eff;
  logic          cin;
  logic [DW:0]   raw;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign cin   = sub_i ? ~(use_c_i & c_i) : (use_c_i & c_i);
  assign raw   = add_c(a_i, b_eff, cin);
  assign sum_o = raw[DW-1:0];
  assign c_o   = sub_i ? ~raw[DW] : raw[DW];
  assign v_o   = (a_i[DW-1] == b_eff[DW-1]) && (sum_o[DW-1] != a_i[DW-1]);
endmodule

// File: rtl/cadd_alu_rot.sv
module cadd_alu_rot
  import cadd_alu_pkg::*;
(
  input  logic [DW-1:0]   y_i,
  input  logic [SH_W-1:0] amt_i,
  input  logic            c_i,
  output logic [DW-1:0]   rot_o,
  output logic            c_o,
  output logic            zero_o
);
  assign zero_o = (amt_i == '0);
  assign rot_o  = rotr(y_i, amt_i);
  assign c_o    = zero_o ? c_i : rot_o[DW-1];
endmodule

// File: rtl/cadd_alu.sv
module cadd_alu
  import cadd_alu_pkg::*;
(
  input  logic [3:0]  op_i,
  input  logic [15:0] y_i,
  input  logic [15:0] x_i,
  input  logic [3:0]  xfield_i,
  input  logic [3:0]  flags_i,
  output logic [15:0] result_o,
  output logic [3:0]  flags_o,
  output logic        flags_we_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // Named internal events for the checker
  logic          cond_true;
  logic          rot_zero;
  logic          is_rot;
  logic          is_logic;
  logic          silent;
  logic [DW-1:0] imm, ofs;

  cadd_alu_opdec u_dec (
    .xfield_i(xfield_i), .x_i(x_i), .flags_i(flags_i),
    .imm_o(imm), .ofs_o(ofs), .cond_true_o(cond_true)
  );

  // Arithmetic path
  logic          use_imm, is_sub, use_c;
  logic [DW-1:0] ar_b, ar_sum;
  logic          ar_c, ar_v;

  assign use_imm = (op == OP_ADDIS) || (op == OP_ADDI);
  assign is_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign use_c   = (op == OP_ADC) || (op == OP_SBC);
  assign ar_b    = use_imm ? imm : x_i;

  cadd_alu_arith u_arith (
    .a_i(y_i), .b_i(ar_b), .sub_i(is_sub), .use_c_i(use_c), .c_i(flags_i[FC]),
    .sum_o(ar_sum), .c_o(ar_c), .v_o(ar_v)
  );

  // Rotate path
  logic [SH_W-1:0] rot_amt;
  logic [DW-1:0]   rot_val;
  logic            rot_c;

  assign rot_amt = (op == OP_RRCI) ? xfield_i[SH_W-1:0] : x_i[SH_W-1:0];

  cadd_alu_rot u_rot (
    .y_i(y_i), .amt_i(rot_amt), .c_i(flags_i[FC]),
    .rot_o(rot_val), .c_o(rot_c), .zero_o(rot_zero)
  );

  assign is_rot   = (op == OP_RRCI) || (op == OP_RRC);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign silent   = (op == OP_ADDIS) || (op == OP_ADDS) || (op == OP_CADD)
                 || (op == OP_RSV0) || (op == OP_RSV1);

  // Result select and flag value
  logic [DW-1:0] res, zn_src;
  logic          nc, nv;

  always_comb begin
    res = y_i;
    nc  = ar_c;
    nv  = ar_v;
    unique case (op)
      OP_ADDIS, OP_ADDI, OP_ADDS, OP_ADD, OP_ADC, OP_SUB, OP_SBC:
        res = ar_sum;
      OP_AND: begin res = y_i & x_i; nc = 1'b0; nv = 1'b0; end
      OP_OR:  begin res = y_i | x_i; nc = 1'b0; nv = 1'b0; end
      OP_XOR: begin res = y_i ^ x_i; nc = 1'b0; nv = 1'b0; end
      OP_CMP:  res = y_i;
      OP_CADD: res = cond_true ? (y_i + ofs) : y_i;
      OP_RRCI, OP_RRC: begin res = rot_val; nc = rot_c; nv = 1'b0; end
      default: res = y_i;
    endcase
  end

  assign zn_src     = (op == OP_CMP) ? ar_sum : res;
  assign result_o   = res;
  assign flags_we_o = ~silent;
  assign flags_o    = silent ? flags_i
                    : {nv, zn_src[DW-1], nc, (zn_src == '0)};
endmodule

// File: rtl/cadd_alu_chk.sv
module cadd_alu_chk
  import cadd_alu_pkg::*;
(
  input logic [3:0]  op_i,
  input logic [15:0] y_i,
  input logic [3:0]  flags_i,
  input logic [15:0] result_o,
  input logic [3:0]  flags_o,
  input logic        flags_we_o,
  input logic        cond_true,
  input logic        rot_zero,
  input logic        is_rot,
  input logic        is_logic
);
  always_comb begin
    // R3: silent ops pass flags through untouched
    if (op_i == 4'd0 || op_i == 4'd2 || op_i == 4'd11)
      a_r3_silent_keeps_flags: assert (!flags_we_o && flags_o == flags_i);
    // R4: compare result is Y
    if (op_i == 4'd10)
      a_r4_cmp_returns_y: assert (result_o == y_i);
    // R6: failed condition returns Y
    if (op_i == 4'd11 && !cond_true)
      a_r6_cadd_false_keeps_y: assert (result_o == y_i);
    // R5: logic ops clear C and V
    if (is_logic)
      a_r5_logic_clears_cv: assert (!flags_o[FC] && !flags_o[FV]);
    // R9: zero rotate count keeps Y and C
    if (is_rot && rot_zero)
      a_r9_rot_zero_noop: assert (result_o == y_i && flags_o[FC] == flags_i[FC]);
    // R8: nonzero rotate puts last bit out in C
    if (is_rot && !rot_zero)
      a_r8_rot_carry_msb: assert (flags_o[FC] == result_o[15] && !flags_o[FV]);
    // R10: reserved ops
    if (op_i >= 4'd14)
      a_r10_reserved_inert: assert (result_o == y_i && !flags_we_o);
    // R11: Z tracks the result on written flags (except compare)
    if (flags_we_o && op_i != 4'd10)
      a_r11_zero_flag: assert (flags_o[FZ] == (result_o == 16'd0));
  end
endmodule

bind cadd_alu cadd_alu_chk u_chk (
  .op_i(op_i), .y_i(y_i), .flags_i(flags_i), .result_o(result_o),
  .flags_o(flags_o), .flags_we_o(flags_we_o), .cond_true(cond_true),
  .rot_zero(rot_zero), .is_rot(is_rot), .is_logic(is_logic)
);

// File: tb/cadd_alu_tb.sv
module cadd_alu_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic [3:0]  op, xf, fi, fo;
  logic [15:0] y, x, res;
  logic        we;
  int total = 0, bad = 0;
  bit done = 0;

  cadd_alu u_dut (
    .op_i(op), .y_i(y), .x_i(x), .xfield_i(xf), .flags_i(fi),
    .result_o(res), .flags_o(fo), .flags_we_o(we)
  );

  function automatic int sgn(input logic [15:0] v);
    return v[15] ? int'(v) - 65536 : int'(v);
  endfunction

  // Expected {we, flags, result}
  function automatic logic [20:0] model(input logic [3:0] o, input logic [15:0] yy,
      input logic [15:0] xx, input logic [3:0] f, input logic [3:0] fin);
    logic [15:0] r, zv, b;
    logic c, v, w, t;
    int s, u, n, cin, ofs;
    r = yy; c = fin[1]; v = fin[3]; w = 1'b1; zv = 16'h0;
    cin = (o == 4 || o == 6) ? int'(fin[1]) : 0;
    b = (o <= 1) ? 16'(f[3] ? int'(f) - 16 : int'(f)) : xx;
    case (o)
      0, 1, 2, 3, 4: begin
        u = int'(yy) + int'(b) + cin; s = sgn(yy) + sgn(b) + cin;
        r = 16'(u); c = u > 65535; v = s > 32767 || s < -32768;
      end
      5, 6, 10: begin
        u = int'(yy) - int'(xx) - cin; s = sgn(yy) - sgn(xx) - cin;
        r = 16'(u); c = u < 0; v = s > 32767 || s < -32768;
      end
      7: begin r = yy & xx; c = 0; v = 0; end
      8: begin r = yy | xx; c = 0; v = 0; end
      9: begin r = yy ^ xx; c = 0; v = 0; end
      11: begin
        case (xx[15:13])
          0: t = fin[0]; 1: t = !fin[0]; 2: t = fin[1]; 3: t = !fin[1];
          4: t = fin[2]; 5: t = !fin[2]; 6: t = fin[3]; default: t = 1;
        endcase
        ofs = xx[12] ? int'(xx[12:0]) - 8192 : int'(xx[12:0]);
        r = t ? 16'(int'(yy) + ofs) : yy;
      end
      12, 13: begin
        n = (o == 12) ? int'(f) % 16 : int'(xx) % 16;
        v = 0;
        if (n != 0) begin
          r = (yy >> n) | (yy << (16 - n)); c = yy[n-1];
        end
      end
      default: r = yy;
    endcase
    if (o == 0 || o == 2 || o == 11 || o >= 14) w = 0;
    zv = (o == 10) ? r : r;
    if (o == 10) r = yy;
    if (!w) return {1'b0, fin, r};
    return {1'b1, v, zv[15], c, zv == 16'h0, r};
  endfunction

  task automatic apply(input logic [3:0] o, input logic [15:0] yy, input logic [15:0] xx,
                       input logic [3:0] f, input logic [3:0] fin, input string tag);
    logic [20:0] exp;
    @(negedge clk);
    op = o; y = yy; x = xx; xf = f; fi = fin;
    #2;
    exp = model(o, yy, xx, f, fin);
    total++;
    if ({we, fo, res} !== exp) begin
      bad++;
      $display("FAIL %s op=%0d y=%h x=%h xf=%h fi=%h got we=%b f=%h r=%h exp we=%b f=%h r=%h",
               tag, o, yy, xx, f, fin, we, fo, res, exp[20], exp[19:16], exp[15:0]);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      0, 1: return "R1";
      2, 3, 4: return "R2";
      5, 6, 10: return "R4";
      7, 8, 9: return "R5";
      11: return "R6";
      12, 13: return "R8";
      default: return "R10";
    endcase
  endfunction

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    op = 0; y = 0; x = 0; xf = 0; fi = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset-state-like quiet vector: move of zero, flags untouched (R1, R3)
    apply(0, 16'h0000, 16'h0, 4'h0, 4'h0, "R1 idle");
    // R1: immediate extremes
    apply(1, 16'h0005, 16'h0, 4'h8, 4'h0, "R1 imm -8");
    apply(1, 16'hFFF9, 16'h0, 4'h7, 4'h0, "R1 imm +7 wrap");
    apply(0, 16'h1234, 16'h0, 4'hF, 4'hA, "R1 R3 silent -1");
    // R2: overflow and carry
    apply(3, 16'h7FFF, 16'h0001, 4'h0, 4'h0, "R2 V");
    apply(4, 16'hFFFF, 16'h0000, 4'h0, 4'h2, "R2 C in");
    apply(2, 16'hFFFF, 16'h0001, 4'h0, 4'h5, "R2 R3 silent");
    // R4: borrow and compare
    apply(5, 16'h0001, 16'h0002, 4'h0, 4'h0, "R4 borrow");
    apply(6, 16'h0005, 16'h0005, 4'h0, 4'h2, "R4 sbc");
    apply(10, 16'h8000, 16'h0001, 4'h0, 4'h0, "R4 R11 cmp");
    apply(10, 16'h0042, 16'h0042, 4'h0, 4'h0, "R11 cmp eq");
    // R5
    apply(7, 16'hF0F0, 16'h0F0F, 4'h0, 4'hF, "R5 and");
    apply(9, 16'h8001, 16'h0001, 4'h0, 4'hA, "R5 xor");
    // R6 R7: all condition codes, both flag polarities, offset extremes
    for (int cc = 0; cc < 8; cc++)
      for (int pol = 0; pol < 2; pol++) begin
        apply(11, 16'h1000, {3'(cc), 13'h0FFF}, 4'h0, pol ? 4'hF : 4'h0, "R7 cadd +max");
        apply(11, 16'h1000, {3'(cc), 13'h1000}, 4'h0, pol ? 4'hF : 4'h0, "R6 cadd -min");
        apply(11, 16'h2000, {3'(cc), 13'h1FFE}, 4'h0, pol ? 4'h5 : 4'hA, "R7 cadd mix");
      end
    // R8 R9: rotates
    apply(12, 16'h0001, 16'h0, 4'h1, 4'h0, "R8 rrci 1");
    apply(13, 16'h8003, 16'h0004, 4'h0, 4'h0, "R8 rrc 4");
    apply(12, 16'h0002, 16'h0, 4'hF, 4'h0, "R8 rrci -1");
    for (int cin = 0; cin < 2; cin++) begin
      apply(12, 16'hABCD, 16'h0, 4'h0, cin ? 4'h2 : 4'h0, "R9 rrci 0");
      apply(13, 16'hABCD, 16'h0010, 4'h0, cin ? 4'h2 : 4'h0, "R9 rrc 16");
      apply(13, 16'h0000, 16'h0020, 4'h0, cin ? 4'hA : 4'h8, "R9 R11 rrc 32");
    end
    // R10
    apply(14, 16'h5555, 16'hAAAA, 4'h3, 4'h6, "R10 op14");
    apply(15, 16'h0000, 16'hFFFF, 4'hC, 4'h9, "R10 op15");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] o;
      o = 4'($urandom);
      apply(o, 16'($urandom), 16'($urandom), 4'($urandom), 4'($urandom), tag_of(o));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule